// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider Controller

This block sits in the feedback path of an integer-N phase-locked loop. It runs on the output clock of an external dual-modulus prescaler. A two-bit mode input sets the prescaler's base modulus P, and the modulus-control output chooses between P and P+1 for each prescaler cycle. Two down-counters set the ratio. The swallow count A gives the number of prescaler cycles that use P+1. The main count B gives the total number of prescaler cycles in one output period. One period therefore spans N = B·P + A cycles of the high-rate input.

Once per period the block emits a divided pulse for the phase detector. When the main count expires, both counters reload from the programmed values. The prescaler mode is latched at the same moment, so a change to A, B or the mode never produces a period with a mixed ratio. If B is not larger than A, the configuration cannot be realised. The block then raises an error flag and keeps both of its control outputs low until a valid setting arrives.

Top module: `psd_divider`

## Requirements
- R1: In steady state, consecutive rising edges of `div_pulse` are B·P + A high-rate input cycles apart.
- R2: `mod_ctl` (1 selects P+1, 0 selects P) is high for the first A prescaler cycles of each output period and low for the remaining B−A cycles.
- R3: `div_pulse` rises once every B prescaler cycles. It is high for exactly the first prescaler cycle of each period.
- R4: `psc_mode` reports the mode in force, with encoding 0 for 8/9, 1 for 16/17, 2 for 32/33 and 3 for 64/65, so P = 8·2^mode.
- R5: While the sampled B is less than or equal to the sampled A, `cfg_err` is high and both `div_pulse` and `mod_ctl` stay low. A valid setting clears `cfg_err` and restarts the pulses.
- R6: A change to `a_val`, `b_val` or `mode_sel` in the middle of a period leaves that period at the old ratio. The new ratio applies from the next reload.
- R7: While `rst` is high, `mod_ctl`, `div_pulse` and `cfg_err` are low and `psc_mode` is 0. These values are visible after the first clock edge with reset asserted.
- R8: With A = 0, `mod_ctl` never goes high and the ratio is B·P.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Prescaler output clock |
| rst | input | 1 | Synchronous active-high reset |
| a_val | input | A_W (6) | Swallow count A |
| b_val | input | B_W (13) | Main count B |
| mode_sel | input | 2 | Requested prescaler mode |
| mod_ctl | output | 1 | Modulus control: 1 = P+1, 0 = P |
| div_pulse | output | 1 | One pulse per output period |
| cfg_err | output | 1 | Set while B ≤ A |
| psc_mode | output | 2 | Prescaler mode latched at the last valid reload |

## Verification
Two events can land on the same prescaler edge: the reload at the main count's terminal value, and a new setting on the inputs.

The bench changes A, B and the mode right after a pulse, in the middle of a period. It then checks that the period in progress still matches the old ratio and that the next period matches the new one, measured in high-rate cycles.

A second collision happens on recovery from an error. In that state the block reloads on every edge, so a valid setting is taken up on the very next edge. The bench checks that pulses resume and that the first full period after recovery has the exact new ratio and swallow count.

// File: rtl/psd_pkg.sv
package psd_pkg;
  localparam int PSD_A_W = 6;
  localparam int PSD_B_W = 13;

  typedef enum logic [1:0] {
    PSC_8_9   = 2'd0,
    PSC_16_17 = 2'd1,
    PSC_32_33 = 2'd2,
    PSC_64_65 = 2'd3
  } psc_mode_e;
endpackage

// File: rtl/psd_cfg_check.sv
module psd_cfg_check #(
  parameter int A_W = 6,
  parameter int B_W = 13
) (
  input  logic [A_W-1:0] a_in,
  input  logic [B_W-1:0] b_in,
  output logic           ok
);
  localparam int CW = (A_W > B_W) ? A_W : B_W;

  logic [CW-1:0] a_x;
  logic [CW-1:0] b_x;

  assign a_x = CW'(a_in);
  assign b_x = CW'(b_in);
  // valid only when the main count strictly exceeds the swallow count
  assign ok  = (b_x > a_x);
endmodule

// File: rtl/psd_main_cnt.sv
module psd_main_cnt #(
  parameter int B_W = 13
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ld,
  input  logic           ok,
  input  logic [B_W-1:0] b_in,
  output logic [B_W-1:0] cnt,
  output logic           term
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (ld) begin
      // on an invalid setting stay at zero so the next edge reloads again
      cnt <= ok ? (b_in - B_W'(1)) : '0;
    end else begin
      cnt <= cnt - B_W'(1);
    end
  end

  assign term = (cnt == '0);
endmodule

// File: rtl/psd_swallow_cnt.sv
module psd_swallow_cnt #(
  parameter int A_W = 6
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ld,
  input  logic           ok,
  input  logic [A_W-1:0] a_in,
  output logic           mod
);
  logic [A_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      mod <= 1'b0;
    end else if (ld) begin
      cnt <= ok ? a_in : '0;
      mod <= ok && (a_in != '0);
    end else begin
      if (cnt != '0) cnt <= cnt - A_W'(1);
      // stays high while a further P+1 cycle remains after this one
      mod <= (cnt > A_W'(1));
    end
  end
endmodule

// File: rtl/psd_divider.sv
module psd_divider
  import psd_pkg::*;
#(
  parameter int A_W = PSD_A_W,
  parameter int B_W = PSD_B_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [A_W-1:0] a_val,
  input  logic [B_W-1:0] b_val,
  input  logic [1:0]     mode_sel,
  output logic           mod_ctl,
  output logic           div_pulse,
  output logic           cfg_err,
  output logic [1:0]     psc_mode
);
  logic           load;
  logic           cfg_ok;
  logic [B_W-1:0] b_cnt;
  psc_mode_e      mode_q;

  psd_cfg_check #(.A_W(A_W), .B_W(B_W)) u_cfg (
    .a_in (a_val),
    .b_in (b_val),
    .ok   (cfg_ok)
  );

  psd_main_cnt #(.B_W(B_W)) u_main (
    .clk  (clk),
    .rst  (rst),
    .ld   (load),
    .ok   (cfg_ok),
    .b_in (b_val),
    .cnt  (b_cnt),
    .term (load)
  );

  psd_swallow_cnt #(.A_W(A_W)) u_swal (
    .clk  (clk),
    .rst  (rst),
    .ld   (load),
    .ok   (cfg_ok),
    .a_in (a_val),
    .mod  (mod_ctl)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      div_pulse <= 1'b0;
      cfg_err   <= 1'b0;
      mode_q    <= PSC_8_9;
    end else begin
      div_pulse <= load && cfg_ok;
      if (load) cfg_err <= !cfg_ok;
      if (load && cfg_ok) mode_q <= psc_mode_e'(mode_sel);
    end
  end

  assign psc_mode = mode_q;
endmodule

// File: rtl/psd_divider_chk.sv
module psd_divider_chk #(
  parameter int B_W = 13
) (
  input logic           clk,
  input logic           rst,
  input logic           load,
  input logic [B_W-1:0] b_cnt,
  input logic           mod_ctl,
  input logic           div_pulse,
  input logic           cfg_err,
  input logic [1:0]     psc_mode
);
  // R2: P+1 is only entered at the start of a period
  p_mod_rise_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(mod_ctl) |-> div_pulse);

  // R3: a pulse always follows a terminal count of the main counter
  p_pulse_after_term_r3: assert property (@(posedge clk) disable iff (rst)
    div_pulse |-> $past(load));

  // R3: between reloads the main counter steps down by one per edge
  p_bcnt_step_r3: assert property (@(posedge clk) disable iff (rst)
    !load |=> (b_cnt == $past(b_cnt) - B_W'(1)));

  // R5: an error holds both control outputs low
  p_err_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> (!div_pulse && !mod_ctl));

  // R6: the mode only moves on a reload edge
  p_mode_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(psc_mode));

  // R7: reset clears the outputs
  p_reset_clear_r7: assert property (@(posedge clk)
    rst |=> (!div_pulse && !mod_ctl && !cfg_err && psc_mode == 2'd0));
endmodule

bind psd_divider psd_divider_chk #(.B_W(B_W)) u_sva (
  .clk       (clk),
  .rst       (rst),
  .load      (load),
  .b_cnt     (b_cnt),
  .mod_ctl   (mod_ctl),
  .div_pulse (div_pulse),
  .cfg_err   (cfg_err),
  .psc_mode  (psc_mode)
);

// File: tb/psd_divider_tb.sv
`timescale 1ns/1ps
module psd_divider_tb;
  logic        vco = 1'b0;
  logic        pclk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  a_val = 6'd5;
  logic [12:0] b_val = 13'd20;
  logic [1:0]  mode_sel = 2'd0;
  logic        mod_ctl, div_pulse, cfg_err;
  logic [1:0]  psc_mode;

  int n_chk = 0, n_fail = 0;
  int cur_n = 165;

  always #5 vco = ~vco;

  psd_divider u_dut (
    .clk(pclk), .rst(rst), .a_val(a_val), .b_val(b_val), .mode_sel(mode_sel),
    .mod_ctl(mod_ctl), .div_pulse(div_pulse), .cfg_err(cfg_err), .psc_mode(psc_mode)
  );

  // behavioural dual-modulus prescaler: length chosen one input cycle after its output edge
  int pc = 0;
  int sw_total = 0, pk_total = 0;
  always @(posedge vco) begin
    if (pc == 0) pc <= (8 << psc_mode) + (mod_ctl ? 1 : 0) - 1;
    else         pc <= pc - 1;
    pclk <= (pc == 1);
    if (pc == 0 && mod_ctl) sw_total <= sw_total + 1;
    if (pc == 1) pk_total <= pk_total + 1;
  end

  // period monitor, sampled away from the active edge
  int vtot = 0, v_last = 0, sw_last = 0, pk_last = 0;
  int period = 0, sw_per = 0, pk_per = 0, hi_w = 0, pulse_n = 0;
  logic pulse_d = 1'b0;
  always @(negedge vco) begin
    vtot = vtot + 1;
    if (div_pulse && !pulse_d) begin
      period  = vtot - v_last;
      v_last  = vtot;
      sw_per  = sw_total - sw_last;
      sw_last = sw_total;
      pk_per  = pk_total - pk_last;
      pk_last = pk_total;
      pulse_n = pulse_n + 1;
    end
    if (!div_pulse && pulse_d) hi_w = vtot - v_last;
    pulse_d = div_pulse;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_pulse();
    int n = pulse_n;
    wait (pulse_n > n);
  endtask

  task automatic t_reset();
    repeat (200) @(negedge vco);
    chk(mod_ctl == 1'b0,   "R7 mod_ctl", mod_ctl, 0);
    chk(div_pulse == 1'b0, "R7 div_pulse", div_pulse, 0);
    chk(cfg_err == 1'b0,   "R7 cfg_err", cfg_err, 0);
    chk(psc_mode == 2'd0,  "R7 psc_mode", psc_mode, 0);
    rst = 1'b0;
    wait_pulse();
  endtask

  task automatic t_ratio(input int a, input int b, input int m);
    int p = 8 << m;
    int exp_n = b * p + a;
    wait_pulse();
    a_val = 6'(a); b_val = 13'(b); mode_sel = 2'(m);
    wait_pulse();
    chk(period == cur_n, "R6 old ratio kept", period, cur_n);
    wait_pulse();
    chk(period == exp_n, "R1 ratio", period, exp_n);
    chk(sw_per == a, (a == 0) ? "R8 no swallow" : "R2 swallow count", sw_per, a);
    chk(pk_per == b, "R3 prescaler cycles per period", pk_per, b);
    chk(hi_w == p + ((a > 0) ? 1 : 0), "R3 pulse width", hi_w, p + ((a > 0) ? 1 : 0));
    chk(psc_mode == 2'(m), "R4 mode", psc_mode, m);
    wait_pulse();
    chk(period == exp_n, "R1 ratio repeat", period, exp_n);
    cur_n = exp_n;
  endtask

  task automatic t_err();
    int bad = 0;
    wait_pulse();
    a_val = 6'd12; b_val = 13'd12;
    repeat (cur_n + 100) @(negedge vco);
    repeat (2000) begin
      @(negedge vco);
      if (div_pulse || mod_ctl) bad++;
    end
    chk(cfg_err == 1'b1, "R5 flag on B equal A", cfg_err, 1);
    chk(bad == 0, "R5 outputs quiet", bad, 0);
    a_val = 6'd0; b_val = 13'd0;
    bad = 0;
    repeat (500) begin
      @(negedge vco);
      if (div_pulse || mod_ctl || !cfg_err) bad++;
    end
    chk(bad == 0, "R5 zero B held in error", bad, 0);
    a_val = 6'd7; b_val = 13'd9; mode_sel = 2'd1;
    wait_pulse();
    chk(cfg_err == 1'b0, "R5 flag clears", cfg_err, 0);
    wait_pulse();
    chk(period == 151, "R5 ratio after recovery", period, 151);
    chk(sw_per == 7, "R5 swallow after recovery", sw_per, 7);
    cur_n = 151;
  endtask

  initial begin
    #2000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_ratio(5, 20, 0);
    t_ratio(0, 10, 1);
    t_ratio(63, 100, 3);
    t_ratio(10, 11, 2);
    t_ratio(3, 4, 0);
    t_err();
    t_ratio(1, 30, 2);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule